// File: doc/BRIEF.md
# Counterflow Systolic Edit-Distance Array

This block computes the minimum edit cost between two short strings over a four-symbol alphabet. It is a linear chain of identical cells. Source symbols enter at the left end and move right by one cell per clock. Target symbols enter at the right end and move left at the same rate. Each string is framed by an opening and a closing separator token. When a source token and a target token land in the same cell on the same clock, that cell updates the costs both tokens carry. It also keeps the result as the diagonal value for the next meeting that takes place in it.

Both input ports number their own symbols, so each symbol enters already carrying its cumulative deletion or insertion cost. The opening separators initialise the diagonal value of every cell they pass. The closing separators pass through the chain without changing anything. The distance travels out of the right end with the last source symbol. When the closing source separator reaches the right end, the block raises a one-cycle done strobe and presents the distance. The chain holds 2*MAX_LEN+1 cells, which is enough for strings of up to MAX_LEN symbols.

Top module: `edsys_array`

## Requirements
- R1: The distance equals the minimum total cost of turning the source into the target. An insertion costs 1 and a deletion costs 1. A substitution costs 2 when the symbols differ and 0 when they are equal.
- R2: Port protocol. On a port, a cycle with valid high and null high is a separator. The first separator opens a string and the next one closes it. A cycle with valid high and null low between them delivers one symbol on the 2-bit char field, with the values 0 to 3 being four distinct symbols. The two opening separators arrive on the same cycle. Successive tokens on a port are exactly two cycles apart. The closing separator never changes a cell's stored cost.
- R3: If either string is empty, the distance equals the length of the other string. If both are empty, the distance is 0.
- R4: The source closing separator is accepted at clock edge T. done_o is then high for exactly the one cycle between edge T+2*MAX_LEN+1 and the edge after it, and it is high at no other time.
- R5: dist_o changes only on the edge that raises done_o, and it holds its value until the next done strobe.
- R6: While valid is low, a port's null and char inputs have no effect on any result.
- R7: After reset, done_o is 0 and dist_o is 0.
- R8: Strings of exactly MAX_LEN symbols, on either side or both, give correct distances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid_i | input | 1 | Source token present this cycle |
| src_null_i | input | 1 | Source token is a separator |
| src_char_i | input | 2 | Source symbol code |
| tgt_valid_i | input | 1 | Target token present this cycle |
| tgt_null_i | input | 1 | Target token is a separator |
| tgt_char_i | input | 2 | Target symbol code |
| done_o | output | 1 | One-cycle strobe: the distance is ready |
| dist_o | output | $clog2(2*MAX_LEN+2) | Edit distance of the last finished pair |

## Verification
The bench is built with MAX_LEN set to 3. It runs every pair of strings of length 0 to 2 against each other, which covers every match and mismatch arrangement of short strings, including empty ones. It then runs random pairs in which at least one string has the full length. Full-length pairs reach the outermost cells and the largest distances, so they separate a correct chain from one that is too short or has wrong end handling. On every idle cycle, the bench drives random null and char values with valid low. On every run, it checks the exact cycle of the done strobe and confirms that no other strobe occurs.

// File: rtl/edsys_pkg.sv
package edsys_pkg;

  // Token classes travelling along the chain.
  typedef enum logic [1:0] {
    TK_HEAD = 2'd0,
    TK_CHAR = 2'd1,
    TK_TAIL = 2'd2
  } tok_kind_e;

  localparam int unsigned CHAR_W   = 2;
  localparam int unsigned COST_INS = 1;
  localparam int unsigned COST_DEL = 1;
  localparam int unsigned COST_SUB = 2;

endpackage

// File: rtl/edsys_feed.sv
// Port front end: classifies separators as opening or closing and tags
// each symbol with its running index (its cumulative boundary cost).
module edsys_feed
  import edsys_pkg::*;
#(
  parameter int unsigned DW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              null_i,
  input  logic [CHAR_W-1:0] ch_i,
  output logic              tok_v_o,
  output tok_kind_e         tok_k_o,
  output logic [CHAR_W-1:0] tok_ch_o,
  output logic [DW-1:0]     tok_val_o
);

  logic          open_q, open_n;
  logic [DW-1:0] cnt_q, cnt_n;

  always_comb begin
    tok_v_o  = valid_i;
    tok_ch_o = ch_i;
    if (null_i) tok_k_o = open_q ? TK_TAIL : TK_HEAD;
    else        tok_k_o = TK_CHAR;
    tok_val_o = (tok_k_o == TK_CHAR) ? cnt_q + DW'(1) : '0;

    open_n = open_q;
    cnt_n  = cnt_q;
    case (tok_k_o)
      TK_HEAD: begin open_n = 1'b1; cnt_n = '0; end
      TK_CHAR: cnt_n = cnt_q + DW'(1);
      default: open_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (valid_i) begin
      open_q <= open_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/edsys_cell.sv
// One processing element: a right-moving source slot, a left-moving target
// slot and the stored diagonal cost of the last meeting in this cell.
module edsys_cell
  import edsys_pkg::*;
#(
  parameter int unsigned DW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_v_i,
  input  tok_kind_e         s_k_i,
  input  logic [CHAR_W-1:0] s_ch_i,
  input  logic [DW-1:0]     s_val_i,
  input  logic              t_v_i,
  input  tok_kind_e         t_k_i,
  input  logic [CHAR_W-1:0] t_ch_i,
  input  logic [DW-1:0]     t_val_i,
  output logic              s_v_o,
  output tok_kind_e         s_k_o,
  output logic [CHAR_W-1:0] s_ch_o,
  output logic [DW-1:0]     s_val_o,
  output logic              t_v_o,
  output tok_kind_e         t_k_o,
  output logic [CHAR_W-1:0] t_ch_o,
  output logic [DW-1:0]     t_val_o
);

  localparam int unsigned CW = DW + 2;

  logic          meet, both_chr, s_head_t_chr, t_head_s_chr, both_head, tail_hit;
  logic [CW-1:0] via_ins, via_del, via_sub, best;
  logic [DW-1:0] s_val_n, t_val_n, diag_n, diag_q;
  logic          diag_en;

  always_comb begin
    meet         = s_v_i && t_v_i;
    both_chr     = meet && (s_k_i == TK_CHAR) && (t_k_i == TK_CHAR);
    s_head_t_chr = meet && (s_k_i == TK_HEAD) && (t_k_i == TK_CHAR);
    t_head_s_chr = meet && (t_k_i == TK_HEAD) && (s_k_i == TK_CHAR);
    both_head    = meet && (s_k_i == TK_HEAD) && (t_k_i == TK_HEAD);
    tail_hit     = meet && ((s_k_i == TK_TAIL) || (t_k_i == TK_TAIL));

    via_ins = CW'(s_val_i) + CW'(COST_INS);
    via_del = CW'(t_val_i) + CW'(COST_DEL);
    via_sub = CW'(diag_q) + ((s_ch_i == t_ch_i) ? CW'(0) : CW'(COST_SUB));
    best = via_ins;
    if (via_del < best) best = via_del;
    if (via_sub < best) best = via_sub;

    s_val_n = s_val_i;
    t_val_n = t_val_i;
    diag_n  = diag_q;
    diag_en = 1'b0;
    if (both_chr) begin
      s_val_n = best[DW-1:0];
      t_val_n = best[DW-1:0];
      diag_n  = best[DW-1:0];
      diag_en = 1'b1;
    end else if (s_head_t_chr) begin
      s_val_n = t_val_i;
      diag_n  = t_val_i;
      diag_en = 1'b1;
    end else if (t_head_s_chr) begin
      t_val_n = s_val_i;
      diag_n  = s_val_i;
      diag_en = 1'b1;
    end else if (both_head) begin
      diag_n  = '0;
      diag_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_v_o <= 1'b0;
      t_v_o <= 1'b0;
    end else begin
      s_v_o <= s_v_i;
      t_v_o <= t_v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_k_o   <= TK_HEAD;
      s_ch_o  <= '0;
      s_val_o <= '0;
    end else if (s_v_i) begin
      s_k_o   <= s_k_i;
      s_ch_o  <= s_ch_i;
      s_val_o <= s_val_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_k_o   <= TK_HEAD;
      t_ch_o  <= '0;
      t_val_o <= '0;
    end else if (t_v_i) begin
      t_k_o   <= t_k_i;
      t_ch_o  <= t_ch_i;
      t_val_o <= t_val_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       diag_q <= '0;
    else if (diag_en) diag_q <= diag_n;
  end

  // R1: neighbouring costs along a row differ by at most one
  assert_row_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    both_chr |=> (CW'(s_val_o) <= CW'($past(s_val_i)) + CW'(1)) &&
                 (CW'(s_val_o) + CW'(1) >= CW'($past(s_val_i))));

  // R1: a cost never drops below, nor exceeds by more than two, its diagonal
  assert_diag_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    both_chr |=> (diag_q >= $past(diag_q)) &&
                 (CW'(diag_q) <= CW'($past(diag_q)) + CW'(2)));

  // R2: a closing separator leaves the stored cost untouched
  assert_tail_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tail_hit |=> $stable(diag_q));

endmodule

// File: rtl/edsys_tap.sv
// Right-end collector: remembers the cost of the last exiting source token
// and publishes it when the closing source separator leaves the chain.
module edsys_tap
  import edsys_pkg::*;
#(
  parameter int unsigned DW       = 5,
  parameter int unsigned MAX_DIST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_v_i,
  input  tok_kind_e     s_k_i,
  input  logic [DW-1:0] s_val_i,
  output logic          done_o,
  output logic [DW-1:0] dist_o
);

  logic last_en, done_n;
  logic [DW-1:0] last_q;

  always_comb begin
    last_en = s_v_i && (s_k_i != TK_TAIL);
    done_n  = s_v_i && (s_k_i == TK_TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (last_en) last_q <= s_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      dist_o <= '0;
    end else begin
      done_o <= done_n;
      if (done_n) dist_o <= last_q;
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_dist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(dist_o));

  assert_dist_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (dist_o <= DW'(MAX_DIST)));

endmodule

// File: rtl/edsys_array.sv
module edsys_array
  import edsys_pkg::*;
#(
  parameter  int unsigned MAX_LEN = 8,
  localparam int unsigned DIST_W  = $clog2(2*MAX_LEN+2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid_i,
  input  logic              src_null_i,
  input  logic [CHAR_W-1:0] src_char_i,
  input  logic              tgt_valid_i,
  input  logic              tgt_null_i,
  input  logic [CHAR_W-1:0] tgt_char_i,
  output logic              done_o,
  output logic [DIST_W-1:0] dist_o
);

  localparam int unsigned NPE = 2*MAX_LEN + 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Link p of the source chain feeds cell p; link p+1 of the target chain feeds cell p.
  logic              s_v   [0:NPE];
  tok_kind_e         s_k   [0:NPE];
  logic [CHAR_W-1:0] s_ch  [0:NPE];
  logic [DIST_W-1:0] s_val [0:NPE];
  logic              t_v   [0:NPE];
  tok_kind_e         t_k   [0:NPE];
  logic [CHAR_W-1:0] t_ch  [0:NPE];
  logic [DIST_W-1:0] t_val [0:NPE];

  edsys_feed #(.DW(DIST_W)) u_src_feed (
    .clk(clk), .rst_n(rst_n_int),
    .valid_i(src_valid_i), .null_i(src_null_i), .ch_i(src_char_i),
    .tok_v_o(s_v[0]), .tok_k_o(s_k[0]), .tok_ch_o(s_ch[0]), .tok_val_o(s_val[0])
  );

  edsys_feed #(.DW(DIST_W)) u_tgt_feed (
    .clk(clk), .rst_n(rst_n_int),
    .valid_i(tgt_valid_i), .null_i(tgt_null_i), .ch_i(tgt_char_i),
    .tok_v_o(t_v[NPE]), .tok_k_o(t_k[NPE]), .tok_ch_o(t_ch[NPE]), .tok_val_o(t_val[NPE])
  );

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    edsys_cell #(.DW(DIST_W)) u_cell (
      .clk(clk), .rst_n(rst_n_int),
      .s_v_i(s_v[p]),     .s_k_i(s_k[p]),     .s_ch_i(s_ch[p]),     .s_val_i(s_val[p]),
      .t_v_i(t_v[p+1]),   .t_k_i(t_k[p+1]),   .t_ch_i(t_ch[p+1]),   .t_val_i(t_val[p+1]),
      .s_v_o(s_v[p+1]),   .s_k_o(s_k[p+1]),   .s_ch_o(s_ch[p+1]),   .s_val_o(s_val[p+1]),
      .t_v_o(t_v[p]),     .t_k_o(t_k[p]),     .t_ch_o(t_ch[p]),     .t_val_o(t_val[p])
    );
  end

  for (genvar p = 0; p < NPE - 1; p++) begin : g_chk
    // R2: opposite tokens in adjacent cells would swap without meeting
    assert_no_cross_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
      !(s_v[p+1] && t_v[p+1]));
  end

  edsys_tap #(.DW(DIST_W), .MAX_DIST(2*MAX_LEN)) u_tap (
    .clk(clk), .rst_n(rst_n_int),
    .s_v_i(s_v[NPE]), .s_k_i(s_k[NPE]), .s_val_i(s_val[NPE]),
    .done_o(done_o), .dist_o(dist_o)
  );

  // Target tokens leaving the left end and source symbols at the right end are dropped.
  logic unused_left;
  assign unused_left = ^{t_v[0], t_k[0], t_ch[0], t_val[0], s_ch[NPE]};

endmodule

// File: tb/tb_edsys_array.sv
module tb_edsys_array;

  localparam int L   = 3;
  localparam int NPE = 2*L + 1;
  localparam int DW  = $clog2(2*L+2);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_valid, src_null, tgt_valid, tgt_null;
  logic [1:0]    src_char, tgt_char;
  logic          done_o;
  logic [DW-1:0] dist_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int sbuf [0:L-1];
  int tbuf [0:L-1];

  always #2 clk = ~clk;

  edsys_array #(.MAX_LEN(L)) dut (
    .clk(clk), .rst_n(rst_n),
    .src_valid_i(src_valid), .src_null_i(src_null), .src_char_i(src_char),
    .tgt_valid_i(tgt_valid), .tgt_null_i(tgt_null), .tgt_char_i(tgt_char),
    .done_o(done_o), .dist_o(dist_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_dist(input int m, input int n);
    int d [0:L][0:L];
    for (int i = 0; i <= m; i++) d[i][0] = i;
    for (int j = 0; j <= n; j++) d[0][j] = j;
    for (int i = 1; i <= m; i++)
      for (int j = 1; j <= n; j++) begin
        int b;
        b = d[i-1][j] + 1;
        if (d[i][j-1] + 1 < b) b = d[i][j-1] + 1;
        if (d[i-1][j-1] + ((sbuf[i-1] == tbuf[j-1]) ? 0 : 2) < b)
          b = d[i-1][j-1] + ((sbuf[i-1] == tbuf[j-1]) ? 0 : 2);
        d[i][j] = b;
      end
    return d[m][n];
  endfunction

  // Drives one pair (tokens every second cycle, random junk with valid low
  // in between, R6) and checks the done cycle (R4), distance and hold (R5).
  task automatic run(input int m, input int n, input string tag);
    int  exp, total, done_step;
    bit  spurious;
    exp       = ref_dist(m, n);
    total     = 2*(((m > n) ? m : n) + 2) + NPE + 2;
    done_step = 2*(m+1) + 1 + NPE;
    spurious  = 1'b0;
    for (int st = 0; st < total; st++) begin
      @(negedge clk);
      if (st == done_step) begin
        check(done_o === 1'b1, {tag, " R4 done strobe"}, int'(done_o), 1);
        check(int'(dist_o) == exp, {tag, " distance"}, int'(dist_o), exp);
      end else if (done_o !== 1'b0) begin
        spurious = 1'b1;
      end
      if ((st % 2 == 0) && (st / 2 <= m + 1)) begin
        int k = st / 2;
        src_valid = 1'b1;
        src_null  = (k == 0) || (k == m + 1);
        src_char  = src_null ? 2'($urandom) : 2'(sbuf[k-1]);
      end else begin
        src_valid = 1'b0; src_null = 1'($urandom); src_char = 2'($urandom);
      end
      if ((st % 2 == 0) && (st / 2 <= n + 1)) begin
        int k = st / 2;
        tgt_valid = 1'b1;
        tgt_null  = (k == 0) || (k == n + 1);
        tgt_char  = tgt_null ? 2'($urandom) : 2'(tbuf[k-1]);
      end else begin
        tgt_valid = 1'b0; tgt_null = 1'($urandom); tgt_char = 2'($urandom);
      end
    end
    check(!spurious, {tag, " R4 no stray strobe"}, int'(spurious), 0);
    check(int'(dist_o) == exp, {tag, " R5 distance held"}, int'(dist_o), exp);
  endtask

  function automatic string pick_tag(input int m, input int n);
    if (m == 0 || n == 0) return "R3";
    if (m == L || n == L) return "R8";
    return "R1 R2";
  endfunction

  initial begin
    rst_n = 1'b0;
    src_valid = 1'b0; src_null = 1'b0; src_char = '0;
    tgt_valid = 1'b0; tgt_null = 1'b0; tgt_char = '0;
    repeat (3) @(negedge clk);
    check(done_o === 1'b0, "R7 done after reset", int'(done_o), 0);
    check(dist_o === '0, "R7 dist after reset", int'(dist_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done_o === 1'b0, "R7 done after release", int'(done_o), 0);

    // Exhaustive sweep: every pair with lengths 0..2
    for (int m = 0; m <= 2; m++)
      for (int sc = 0; sc < (1 << (2*m)); sc++)
        for (int n = 0; n <= 2; n++)
          for (int tc = 0; tc < (1 << (2*n)); tc++) begin
            for (int i = 0; i < L; i++) begin
              sbuf[i] = (sc >> (2*i)) & 3;
              tbuf[i] = (tc >> (2*i)) & 3;
            end
            run(m, n, pick_tag(m, n));
          end

    // Full-length corners: equal strings and fully mismatched strings (R8)
    for (int i = 0; i < L; i++) begin sbuf[i] = i; tbuf[i] = i; end
    run(L, L, "R8 equal");
    for (int i = 0; i < L; i++) begin sbuf[i] = 0; tbuf[i] = 3; end
    run(L, L, "R8 mismatch");

    // Random pairs with at least one full-length string
    for (int r = 0; r < 1200; r++) begin
      int m, n;
      m = $urandom_range(L, 0);
      n = $urandom_range(L, 0);
      if ($urandom % 2) m = L; else n = L;
      for (int i = 0; i < L; i++) begin
        sbuf[i] = $urandom % 4;
        tbuf[i] = $urandom % 4;
      end
      run(m, n, pick_tag(m, n));
    end

    // Idle cycles always carry junk; these runs name R6 explicitly
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < L; i++) begin sbuf[i] = (i + r) % 4; tbuf[i] = (2*i) % 4; end
      run(L - r, L, "R6 junk with valid low");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule